// File: doc/BRIEF.md
# Two-Level Process Run-Queue Scheduler

This block keeps the runnable processes of one processor in two first-in first-out run queues, one for high priority work and one for low priority work, and hands the processor the next process to execute. A process is named by its workspace pointer. The pointer's address is always even, so bit 0 carries the priority (1 = high). The queues cost no storage inside the block beyond a front and a back register per queue: each queued process holds the pointer to its successor in its own workspace, two words below its base address. Its saved instruction pointer sits one word below the base.

Requests come in on three ports. A wake request carries a pointer whose resume address is already in memory, as for a channel wake-up or a newly started process. A deschedule request ends the running process's turn, as for a timeslice, and carries the instruction pointer to store. A stop request means the running process has halted and leaves the processor without being queued. The block issues a process with a one-cycle `run_valid` pulse that carries the pointer and the restored instruction pointer. It preempts a running low priority process as soon as high priority work is queued. The preempted process is parked in a dedicated register and resumes ahead of all queued low priority work. All memory traffic goes through one request/acknowledge port.

Top module: `prio_run_sched`

The control FSM has these states:
- DECIDE (`S_IDLE`): arbitrates the requests and picks the next action.
- `S_SAVE_IP`: writes the instruction pointer.
- `S_APPEND`: checks whether the target queue is empty.
- `S_LINK`: writes the old tail's link word.
- `S_RD_IP`: reads the head's instruction pointer.
- `S_RD_LINK`: reads the head's successor.
- `S_HSAVE`: spends the extra high priority switch cycles.
- `S_ISSUE`: pulses the issue.

It moves between them as follows:
- From DECIDE, a granted wake goes to `S_APPEND`.
- From DECIDE, a granted deschedule goes to `S_SAVE_IP`, and then to `S_APPEND` on acknowledge.
- From DECIDE, a granted stop stays in DECIDE.
- From DECIDE, a dequeue goes to `S_RD_IP`.
- From DECIDE, resuming the parked process goes straight to `S_ISSUE`.
- `S_APPEND` returns to DECIDE when the queue is empty, and otherwise goes to `S_LINK`, which returns to DECIDE on acknowledge.
- `S_RD_IP` goes to `S_RD_LINK` unless the head is also the tail.
- Once the reads are done, a high priority dequeue passes through `S_HSAVE`, and a low one goes to `S_ISSUE`.
- `S_ISSUE` always returns to DECIDE.

## Requirements
- R1: No low priority process is issued while the high priority queue holds a process; processes of equal priority are issued in arrival order.
- R2: When high priority work is queued while a low priority process runs, the block issues it without waiting for that process to stop, with `run_pre` = 1; every other issue has `run_pre` = 0.
- R3: A granted deschedule writes `dsch_iptr` to the word at (base − 1), where base is the running pointer with bit 0 cleared.
- R4: Appending to a non-empty queue writes the new pointer into the link word at (old tail base − 2); appending to an empty queue makes no memory access.
- R5: Bit 0 of a pointer selects its queue (1 = high, 0 = low), and `run_wptr` returns the pointer unchanged, bit 0 included.
- R6: With a memory that acknowledges one cycle after each request, the time from a wake's acceptance to its issue from an empty queue is exactly `HI_SAVE_CYC` cycles longer for a high priority process than for a low one.
- R7: A preempted low priority process resumes, with the `cur_iptr` value present in its preemption cycle, before any queued low priority process, as soon as no high priority process is running or queued.
- R8: `idle` is 1 exactly when the block is deciding, nothing runs, nothing is parked and both queues are empty (front = not-process value 0); then no issue and no memory request occur.
- R9: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until `mem_ack`; read data is taken in the acknowledge cycle.
- R10: Requests present together are granted one per cycle in the order: high priority wake, deschedule, stop, low priority wake; all of them come before issuing.
- R11: A process taken from a queue is issued with the instruction pointer read from (base − 1).
- R12: After reset, `idle` = 1, and `run_valid`, `mem_req` and all acknowledges are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wake_valid | input | 1 | Wake request valid |
| wake_wptr | input | W | Pointer of the process to make runnable |
| wake_ack | output | 1 | Wake granted this cycle |
| dsch_valid | input | 1 | Deschedule the running process |
| dsch_iptr | input | W | Instruction pointer to store for it |
| dsch_ack | output | 1 | Deschedule granted this cycle |
| stop_valid | input | 1 | Running process halts without requeue |
| stop_ack | output | 1 | Stop granted this cycle |
| cur_iptr | input | W | Live instruction pointer of the running process |
| run_valid | output | 1 | Issue pulse |
| run_wptr | output | W | Issued process pointer |
| run_iptr | output | W | Issued process instruction pointer |
| run_pre | output | 1 | Issue preempts the running process |
| idle | output | 1 | Nothing to run |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | W | Word address |
| mem_wdata | output | W | Write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | W | Read data, valid with acknowledge |

## Verification
The bench aims at the following corner cases, with the symptom a faulty design would show in each:
- Preemption of a running low priority process. A design that waited for it to stop would issue late with `run_pre` clear.
- Resumption of the parked process ahead of an older queued low priority process. Losing the park register would issue the wrong pointer or a stale instruction pointer.
- Simultaneous requests. A wrong arbitration order shows as the wrong acknowledge first and a reordered low queue.
- Single-element queues. A dequeue that wrongly read the link word, or left the front set, would repeat a process or skip the rest of the queue.

The cycle gap between high and low priority issue is measured against a zero-wait memory.

// File: rtl/sched_pkg.sv
package sched_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SAVE_IP,
        S_APPEND,
        S_LINK,
        S_RD_IP,
        S_RD_LINK,
        S_HSAVE,
        S_ISSUE
    } sched_st_e;

    localparam logic PRI_LO = 1'b0;
    localparam logic PRI_HI = 1'b1;

endpackage

// File: rtl/rq_heads.sv
module rq_heads #(
    parameter int          W  = 16,
    parameter logic [W-1:0] NP = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                seed_en,
    input  logic [W-1:0]        seed_p,
    input  logic                tail_en,
    input  logic [W-1:0]        tail_p,
    input  logic                head_en,
    input  logic                head_q,
    input  logic [W-1:0]        head_v,
    output logic [1:0][W-1:0]   front_o,
    output logic [1:0][W-1:0]   back_o,
    output logic [1:0]          empty_o
);

    for (genvar q = 0; q < 2; q++) begin : g_queue
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                front_o[q] <= NP;
                back_o[q]  <= NP;
            end else begin
                if (seed_en && (seed_p[0] == q[0])) begin
                    front_o[q] <= seed_p;
                    back_o[q]  <= seed_p;
                end
                if (tail_en && (tail_p[0] == q[0])) begin
                    back_o[q] <= tail_p;
                end
                if (head_en && (head_q == q[0])) begin
                    front_o[q] <= head_v;
                end
            end
        end
        assign empty_o[q] = (front_o[q] == NP);
    end

    // R4: seeding only happens into an empty queue, linking only into a filled one
    a_r4_seed_empty: assert property (@(posedge clk) disable iff (!rst_n)
        seed_en |-> empty_o[seed_p[0]]);
    a_r4_tail_filled: assert property (@(posedge clk) disable iff (!rst_n)
        tail_en |-> !empty_o[tail_p[0]]);

endmodule

// File: rtl/req_arb.sv
module req_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic open_i,
    input  logic running_i,
    input  logic wake_valid,
    input  logic wake_hi,
    input  logic dsch_valid,
    input  logic stop_valid,
    output logic g_wake,
    output logic g_dsch,
    output logic g_stop
);

    logic hi_wake, own_req;

    always_comb begin
        hi_wake = wake_valid && wake_hi;
        own_req = running_i && (dsch_valid || stop_valid);
        g_wake  = open_i && wake_valid && (wake_hi || !own_req);
        g_dsch  = open_i && running_i && dsch_valid && !hi_wake;
        g_stop  = open_i && running_i && stop_valid && !dsch_valid && !hi_wake;
    end

    // R10: at most one grant per cycle
    a_r10_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({g_wake, g_dsch, g_stop}));

endmodule

// File: rtl/prio_run_sched.sv
module prio_run_sched
    import sched_pkg::*;
#(
    parameter int           W           = 16,
    parameter int           HI_SAVE_CYC = 3,
    parameter logic [W-1:0] NOT_PROC    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wake_valid,
    input  logic [W-1:0] wake_wptr,
    output logic         wake_ack,
    input  logic         dsch_valid,
    input  logic [W-1:0] dsch_iptr,
    output logic         dsch_ack,
    input  logic         stop_valid,
    output logic         stop_ack,
    input  logic [W-1:0] cur_iptr,
    output logic         run_valid,
    output logic [W-1:0] run_wptr,
    output logic [W-1:0] run_iptr,
    output logic         run_pre,
    output logic         idle,
    output logic         mem_req,
    output logic         mem_we,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    input  logic         mem_ack,
    input  logic [W-1:0] mem_rdata
);

    localparam int             CW       = (HI_SAVE_CYC > 1) ? $clog2(HI_SAVE_CYC) : 1;
    localparam logic [CW-1:0]  CNT_LOAD = CW'(HI_SAVE_CYC - 1);

    function automatic logic [W-1:0] ip_slot(input logic [W-1:0] wp);
        return {wp[W-1:1], 1'b0} - W'(1);
    endfunction

    function automatic logic [W-1:0] link_slot(input logic [W-1:0] wp);
        return {wp[W-1:1], 1'b0} - W'(2);
    endfunction

    sched_st_e         st_q, st_d;
    logic [W-1:0]      op_w_q, op_ip_q;
    logic [CW-1:0]     cnt_q;
    logic              run_q, resume_q;
    logic [W-1:0]      cur_w_q;
    logic              sv_q;
    logic [W-1:0]      sv_w_q, sv_ip_q;

    logic [1:0][W-1:0] front, back;
    logic [1:0]        empty;
    logic              g_wake, g_dsch, g_stop, any_g;
    logic              disp_hi, disp_lo, disp_sv;
    logic              dq_start, sv_start;
    logic [W-1:0]      dq_w;
    logic              op_q, is_last;
    sched_st_e         after_rd;

    logic              seed_en, tail_en, head_en;
    logic [W-1:0]      head_v;

    req_arb u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .open_i     (st_q == S_IDLE),
        .running_i  (run_q),
        .wake_valid (wake_valid),
        .wake_hi    (wake_wptr[0]),
        .dsch_valid (dsch_valid),
        .stop_valid (stop_valid),
        .g_wake     (g_wake),
        .g_dsch     (g_dsch),
        .g_stop     (g_stop)
    );

    rq_heads #(.W(W), .NP(NOT_PROC)) u_heads (
        .clk     (clk),
        .rst_n   (rst_n),
        .seed_en (seed_en),
        .seed_p  (op_w_q),
        .tail_en (tail_en),
        .tail_p  (op_w_q),
        .head_en (head_en),
        .head_q  (op_q),
        .head_v  (head_v),
        .front_o (front),
        .back_o  (back),
        .empty_o (empty)
    );

    // decision terms
    always_comb begin
        any_g    = g_wake || g_dsch || g_stop;
        op_q     = op_w_q[0];
        is_last  = (op_w_q == back[op_q]);
        after_rd = op_q ? S_HSAVE : S_ISSUE;
        disp_hi  = !empty[PRI_HI] && (!run_q || !cur_w_q[0]);
        disp_sv  = !run_q && sv_q;
        disp_lo  = !run_q && !empty[PRI_LO];
        dq_start = (st_q == S_IDLE) && !any_g && (disp_hi || (!disp_sv && disp_lo));
        sv_start = (st_q == S_IDLE) && !any_g && !disp_hi && disp_sv;
        dq_w     = disp_hi ? front[PRI_HI] : front[PRI_LO];
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: begin
                if (g_wake)        st_d = S_APPEND;
                else if (g_dsch)   st_d = S_SAVE_IP;
                else if (g_stop)   st_d = S_IDLE;
                else if (dq_start) st_d = S_RD_IP;
                else if (sv_start) st_d = S_ISSUE;
            end
            S_SAVE_IP: if (mem_ack) st_d = S_APPEND;
            S_APPEND:  st_d = empty[op_q] ? S_IDLE : S_LINK;
            S_LINK:    if (mem_ack) st_d = S_IDLE;
            S_RD_IP:   if (mem_ack) st_d = is_last ? after_rd : S_RD_LINK;
            S_RD_LINK: if (mem_ack) st_d = after_rd;
            S_HSAVE:   if (cnt_q == '0) st_d = S_ISSUE;
            S_ISSUE:   st_d = S_IDLE;
            default:   st_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_w_q   <= NOT_PROC;
            op_ip_q  <= '0;
            cnt_q    <= '0;
            run_q    <= 1'b0;
            resume_q <= 1'b0;
            cur_w_q  <= NOT_PROC;
            sv_q     <= 1'b0;
            sv_w_q   <= NOT_PROC;
            sv_ip_q  <= '0;
        end else begin
            unique case (st_q)
                S_IDLE: begin
                    if (g_wake) begin
                        op_w_q <= wake_wptr;
                    end else if (g_dsch) begin
                        op_w_q  <= cur_w_q;
                        op_ip_q <= dsch_iptr;
                        run_q   <= 1'b0;
                    end else if (g_stop) begin
                        run_q <= 1'b0;
                    end else if (dq_start) begin
                        op_w_q   <= dq_w;
                        resume_q <= 1'b0;
                    end else if (sv_start) begin
                        op_w_q   <= sv_w_q;
                        op_ip_q  <= sv_ip_q;
                        resume_q <= 1'b1;
                    end
                end
                S_RD_IP: begin
                    if (mem_ack) begin
                        op_ip_q <= mem_rdata;
                        cnt_q   <= CNT_LOAD;
                    end
                end
                S_RD_LINK: begin
                    if (mem_ack) cnt_q <= CNT_LOAD;
                end
                S_HSAVE: begin
                    if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
                end
                S_ISSUE: begin
                    if (run_q) begin
                        sv_q    <= 1'b1;
                        sv_w_q  <= cur_w_q;
                        sv_ip_q <= cur_iptr;
                    end else if (resume_q) begin
                        sv_q <= 1'b0;
                    end
                    run_q    <= 1'b1;
                    cur_w_q  <= op_w_q;
                    resume_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // outputs and queue-head controls
    always_comb begin
        wake_ack  = g_wake;
        dsch_ack  = g_dsch;
        stop_ack  = g_stop;
        run_valid = (st_q == S_ISSUE);
        run_wptr  = op_w_q;
        run_iptr  = op_ip_q;
        run_pre   = (st_q == S_ISSUE) && run_q;
        idle      = (st_q == S_IDLE) && !run_q && !sv_q && empty[PRI_HI] && empty[PRI_LO];

        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (st_q)
            S_SAVE_IP: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ip_slot(op_w_q);
                mem_wdata = op_ip_q;
            end
            S_LINK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = link_slot(back[op_q]);
                mem_wdata = op_w_q;
            end
            S_RD_IP: begin
                mem_req  = 1'b1;
                mem_addr = ip_slot(op_w_q);
            end
            S_RD_LINK: begin
                mem_req  = 1'b1;
                mem_addr = link_slot(op_w_q);
            end
            default: ;
        endcase

        seed_en = (st_q == S_APPEND) && empty[op_q];
        tail_en = (st_q == S_LINK) && mem_ack;
        head_en = mem_ack && (((st_q == S_RD_IP) && is_last) || (st_q == S_RD_LINK));
        head_v  = (st_q == S_RD_LINK) ? mem_rdata : NOT_PROC;
    end

    // R1: a low priority issue only happens with the high queue empty
    a_r1_hi_first: assert property (@(posedge clk) disable iff (!rst_n)
        (run_valid && !run_wptr[0]) |-> empty[PRI_HI]);

    // R2: queued high work with a low process running starts a dequeue next cycle
    a_r2_preempt_now: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == S_IDLE) && !any_g && run_q && !cur_w_q[0] && !empty[PRI_HI])
        |=> (st_q == S_RD_IP));

    // R3: the save write targets an odd word just below the base
    a_r3_save_odd: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && (st_q == S_SAVE_IP)) |-> (mem_we && mem_addr[0]));

    // R6: every high priority issue from a queue passes the extra save cycles
    a_r6_hi_save: assert property (@(posedge clk) disable iff (!rst_n)
        (run_valid && run_wptr[0]) |-> $past(st_q == S_HSAVE));

    // R7: the parked process is resumed as soon as the processor is free
    a_r7_resume: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == S_IDLE) && !any_g && !run_q && sv_q && empty[PRI_HI])
        |=> (run_valid && (run_wptr == $past(sv_w_q))));

    // R8: an idle block makes no issue and no memory request
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!run_valid && !mem_req));

    // R9: request fields hold until acknowledged
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

endmodule

// File: tb/sim_prio_run_sched.sv
module sim_prio_run_sched;
    localparam int W  = 16;
    localparam int HS = 3;
    localparam int NS = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic         wake_valid = 0, dsch_valid = 0, stop_valid = 0;
    logic [W-1:0] wake_wptr = '0, dsch_iptr = '0, cur_iptr = '0;
    logic         wake_ack, dsch_ack, stop_ack;
    logic         run_valid, run_pre, idle;
    logic [W-1:0] run_wptr, run_iptr;
    logic         mem_req, mem_we, mem_ack;
    logic [W-1:0] mem_addr, mem_wdata, mem_rdata;

    prio_run_sched #(.W(W), .HI_SAVE_CYC(HS)) u0 (
        .clk(clk), .rst_n(rst_n),
        .wake_valid(wake_valid), .wake_wptr(wake_wptr), .wake_ack(wake_ack),
        .dsch_valid(dsch_valid), .dsch_iptr(dsch_iptr), .dsch_ack(dsch_ack),
        .stop_valid(stop_valid), .stop_ack(stop_ack), .cur_iptr(cur_iptr),
        .run_valid(run_valid), .run_wptr(run_wptr), .run_iptr(run_iptr),
        .run_pre(run_pre), .idle(idle),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int total = 0, bad = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // word memory with random wait states
    logic [W-1:0] mem [0:255];
    bit           fast_mem = 0;
    logic         poke_en = 0;
    logic [7:0]   poke_a = '0;
    logic [W-1:0] poke_d = '0;
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            for (int i = 0; i < 256; i++) mem[i] <= '0;
        end else begin
            if (poke_en) mem[poke_a] <= poke_d;
            if (mem_ack) mem_ack <= 1'b0;
            else if (mem_req && (fast_mem || $urandom_range(0, 1) == 1)) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem[mem_addr[7:0]];
                if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            end
        end
    end

    // issue monitor
    int           ev_n = 0, ev_cyc = 0;
    logic [W-1:0] ev_w = '0, ev_ip = '0;
    logic         ev_pre = 0;
    always @(negedge clk) begin
        if (rst_n && run_valid) begin
            ev_n   <= ev_n + 1;
            ev_w   <= run_wptr;
            ev_ip  <= run_iptr;
            ev_pre <= run_pre;
            ev_cyc <= cyc;
        end
    end

    // reference model
    int           qh[$], ql[$];
    int           run_s = -1, sav_s = -1;
    logic [W-1:0] sav_ip = '0;
    logic [W-1:0] exp_ip [NS];
    bit           pri [NS];
    bit           busy [NS];
    int           acc_cyc = 0, last_lat = 0;
    int           e_n;
    logic [W-1:0] e_w, e_ip;
    bit           e_pre;

    function automatic logic [W-1:0] wp(int s);
        return W'(32 + 4 * s) | W'(pri[s]);
    endfunction

    task automatic chk(string tag, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic push(int s);
        busy[s] = 1;
        if (pri[s]) qh.push_back(s);
        else        ql.push_back(s);
    endtask

    task automatic predict();
        int s;
        e_n = 0; e_pre = 0; e_w = '0; e_ip = '0;
        if (qh.size() > 0 && (run_s < 0 || !pri[run_s])) begin
            s = qh.pop_front();
            e_pre = (run_s >= 0);
            if (e_pre) begin sav_s = run_s; sav_ip = cur_iptr; end
            run_s = s; e_n = 1; e_w = wp(s); e_ip = exp_ip[s];
        end else if (run_s < 0) begin
            if (sav_s >= 0) begin
                run_s = sav_s; e_n = 1; e_w = wp(sav_s); e_ip = sav_ip; sav_s = -1;
            end else if (ql.size() > 0) begin
                s = ql.pop_front();
                run_s = s; e_n = 1; e_w = wp(s); e_ip = exp_ip[s];
            end
        end
    endtask

    task automatic wait_ack(int k);
        for (int t = 0; t < 400; t++) begin
            if ((k == 0 && wake_ack) || (k == 1 && dsch_ack) || (k == 2 && stop_ack)) begin
                acc_cyc = cyc;
                @(posedge clk);
                #1;
                return;
            end
            tick();
        end
        chk("R10", "request never granted", 0, 1);
    endtask

    task automatic settle(int base);
        bit midle;
        for (int t = 0; t < 120; t++) begin
            tick();
            if (e_n > 0 && ev_n - base >= e_n) break;
            if (e_n == 0 && t >= 60) break;
        end
        tick();
        tick();
        chk("R1", "issue count", ev_n - base, e_n);
        if (e_n > 0 && ev_n - base == e_n) begin
            chk("R5", "issued pointer", ev_w, e_w);
            chk("R11", "restored iptr", ev_ip, e_ip);
            chk("R2", "preempt flag", ev_pre, e_pre);
            last_lat = ev_cyc - acc_cyc;
        end
        midle = (run_s < 0) && (sav_s < 0) && (qh.size() == 0) && (ql.size() == 0);
        chk("R8", "idle flag", idle, midle);
    endtask

    task automatic set_ip(int s);
        tick();
        poke_en = 1; poke_a = 8'(31 + 4 * s); poke_d = W'($urandom_range(1, 65535));
        exp_ip[s] = poke_d;
        tick();
        poke_en = 0;
    endtask

    function automatic int tail_of(bit p);
        if (p) return (qh.size() > 0) ? qh[qh.size() - 1] : -1;
        return (ql.size() > 0) ? ql[ql.size() - 1] : -1;
    endfunction

    task automatic do_wake(int s);
        int base, prev;
        set_ip(s);
        base = ev_n;
        cur_iptr = W'($urandom);
        wake_wptr = wp(s);
        wake_valid = 1;
        #1;
        wait_ack(0);
        wake_valid = 0;
        prev = tail_of(pri[s]);
        push(s);
        predict();
        settle(base);
        if (prev >= 0) chk("R4", "link word", mem[30 + 4 * prev], wp(s));
    endtask

    task automatic do_dsch();
        int base, s, prev;
        logic [W-1:0] ip;
        s = run_s;
        ip = W'($urandom_range(1, 65535));
        base = ev_n;
        cur_iptr = W'($urandom);
        dsch_iptr = ip;
        dsch_valid = 1;
        #1;
        wait_ack(1);
        dsch_valid = 0;
        exp_ip[s] = ip;
        run_s = -1;
        prev = tail_of(pri[s]);
        push(s);
        predict();
        settle(base);
        chk("R3", "saved iptr word", mem[31 + 4 * s], ip);
        if (prev >= 0) chk("R4", "link word", mem[30 + 4 * prev], wp(s));
    endtask

    task automatic do_stop();
        int base;
        base = ev_n;
        stop_valid = 1;
        #1;
        wait_ack(2);
        stop_valid = 0;
        busy[run_s] = 0;
        run_s = -1;
        predict();
        settle(base);
    endtask

    // wake slot s together with a deschedule of the running process
    task automatic do_pair(int s, int exp_first);
        int base, first, cur;
        bit wd, dd;
        logic [W-1:0] ip;
        set_ip(s);
        cur = run_s;
        ip = W'($urandom_range(1, 65535));
        base = ev_n;
        first = -1; wd = 0; dd = 0;
        wake_wptr = wp(s); wake_valid = 1;
        dsch_iptr = ip; dsch_valid = 1;
        #1;
        for (int t = 0; t < 400 && !(wd && dd); t++) begin
            if (wake_ack && first < 0) first = 0;
            if (dsch_ack && first < 0) first = 1;
            if (wake_ack) begin @(posedge clk); #1; wake_valid = 0; wd = 1; end
            else if (dsch_ack) begin @(posedge clk); #1; dsch_valid = 0; dd = 1; end
            else tick();
        end
        wake_valid = 0; dsch_valid = 0;
        chk("R10", "first grant (0=wake,1=dsch)", first, exp_first);
        exp_ip[cur] = ip;
        run_s = -1;
        if (exp_first == 0) begin push(s); push(cur); end
        else                begin push(cur); push(s); end
        predict();
        settle(base);
    endtask

    // watchdog
    always @(posedge clk) begin
        if (cyc == 150000) begin
            total++; bad++;
            $display("FAIL R1 watchdog: actual=%0d expected=<150000 cycles", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int lat_lo, lat_hi, pick, tries;
        logic [W-1:0] pre_ip;
        void'($urandom(1234));
        for (int i = 0; i < NS; i++) begin pri[i] = i[0]; busy[i] = 0; exp_ip[i] = '0; end
        repeat (5) @(posedge clk);
        #1 rst_n = 1;
        tick();
        // R12 reset state
        chk("R12", "idle after reset", idle, 1);
        chk("R12", "run_valid after reset", run_valid, 0);
        chk("R12", "mem_req after reset", mem_req, 0);
        chk("R12", "acks after reset", {wake_ack, dsch_ack, stop_ack}, 0);

        // R6 switch latency, zero-wait memory
        fast_mem = 1;
        do_wake(0); lat_lo = last_lat; do_stop();
        do_wake(1); lat_hi = last_lat; do_stop();
        chk("R6", "hi minus lo latency", lat_hi - lat_lo, HS);
        fast_mem = 0;

        // R2 and R7 preemption then resume ahead of queued low work
        do_wake(0);
        do_wake(2);
        pre_ip = W'($urandom_range(1, 65535));
        set_ip(3);
        begin
            int base;
            base = ev_n;
            cur_iptr = pre_ip;
            wake_wptr = wp(3); wake_valid = 1;
            #1;
            wait_ack(0);
            wake_valid = 0;
            push(3);
            predict();
            settle(base);
            chk("R2", "preempt on high wake", ev_pre, 1);
        end
        do_stop();
        chk("R7", "resumed pointer", ev_w, wp(0));
        chk("R7", "resumed iptr", ev_ip, pre_ip);

        // R10 simultaneous requests
        do_pair(5, 0);   // high wake beats deschedule
        do_pair(4, 1);   // deschedule beats low wake

        // constrained random traffic
        for (int n = 0; n < 300; n++) begin
            pick = $urandom_range(0, 3);
            if (run_s >= 0 && pick == 0) do_dsch();
            else if (run_s >= 0 && pick == 1) do_stop();
            else begin
                tries = 0;
                pick = $urandom_range(0, NS - 1);
                while (busy[pick] && tries < NS) begin pick = (pick + 1) % NS; tries++; end
                if (!busy[pick]) do_wake(pick);
                else if (run_s >= 0) do_dsch();
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule